// File: doc/BRIEF.md
# Converter Output Formatter

This block sits between a pipelined 10-bit converter core and the parallel output bus. Each conversion clock it takes one raw sample, carries it through a delay line so that the word reaches the bus a fixed number of clocks after it was taken, and then passes it through an output-mode selector. The selector can:

- pass the sample through unchanged,
- invert the top bit, the lower nine bits, or all ten,
- replace the sample with one of four fixed alternating test words,
- force a blanking code,
- drive the bus all-low for standby.

The bus is modelled as a registered data word plus one active-high enable that stands in for the pad tri-state control. Software-held bits select standby, test and the two inversions. Two pin-level inputs give output disable and pre-blanking.

Top module: `adc_out_formatter`

## Requirements
- R1: In normal mode (all controls low), the sample presented before rising edge n appears on `dout` right after edge n+4, which is 5 clocks of total latency. Codes 0, 511 and 1023 pass unchanged.
- R2: While `out_disable` is high, `dout_en` is low in the same cycle, whatever the other controls are. While it is low, `dout_en` is high.
- R3: With `stby` high at an edge, `dout` is all zeros after that edge, whatever `test`, the inversions and `blank_req` are.
- R4: With `test` high and `stby` low, the edge loads a fixed word selected by {`linv`,`minv`}: 00 gives 0x155, 01 gives 0x355, 10 gives 0x0AA and 11 gives 0x2AA.
- R5: In normal mode, `minv` alone inverts bit 9 of the delayed sample, `linv` alone inverts bits 8..0, and both together invert all ten bits.
- R6: With `blank_req` high and every other control low, the edge loads the code 32.
- R7: `blank_req` has no effect when any of `out_disable`, `stby`, `test`, `linv` or `minv` is high. In that case the word those controls select is loaded instead.
- R8: The first edge after `blank_req` falls loads the correctly delayed sample. No held or stale word appears.
- R9: During reset, `dout` and every delay stage read zero. The first four words after reset release, before any real sample arrives, are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; all updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_in | input | 10 | Raw converter sample |
| out_disable | input | 1 | High puts the bus in high impedance |
| blank_req | input | 1 | Pre-blanking request |
| stby | input | 1 | Standby: bus driven all-low |
| test | input | 1 | Test-word mode |
| linv | input | 1 | Invert lower nine bits / test-word select |
| minv | input | 1 | Invert bit 9 / test-word select |
| dout | output | 10 | Registered output word |
| dout_en | output | 1 | Bus drive enable (low means high impedance) |

## Verification
A delay stage that shifts wrongly or resets to a non-zero value shows up on `dout` in normal mode. Such an error appears exactly five edges after the affected sample, or in the first four words after reset. It corrupts a whole run of words, not just one. A wrong mode priority or a wrong inversion mask shows up at the first edge after the controls change, because every mode decision is taken at the single output register. The bench therefore compares every cycle against a queue of words predicted from the stimulus. It uses mode sequences that switch controls on consecutive edges.

// File: rtl/adc_out_formatter.sv
module adc_out_formatter #(
  parameter int W          = 10,
  parameter int LATENCY    = 5,
  parameter int BLANK_CODE = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sample_in,
  input  logic         out_disable,
  input  logic         blank_req,
  input  logic         stby,
  input  logic         test,
  input  logic         linv,
  input  logic         minv,
  output logic [W-1:0] dout,
  output logic         dout_en
);
  localparam int DLY = LATENCY - 1;

  function automatic logic [W-1:0] alt_word();
    logic [W-1:0] w;
    for (int i = 0; i < W; i++) w[i] = (i % 2 == 0);
    return w;
  endfunction

  localparam logic [W-1:0] ALT      = alt_word();
  localparam logic [W-1:0] MSB_MASK = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] LOW_MASK = ~MSB_MASK;
  localparam logic [W-1:0] BLANK    = W'(BLANK_CODE);

  logic [W-1:0] stage_q [DLY];
  logic [W-1:0] tap;
  logic [W-1:0] inv_mask;
  logic         blank_sel;
  logic [W-1:0] word_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DLY; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= sample_in;
      for (int i = 1; i < DLY; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign tap       = stage_q[DLY-1];
  assign inv_mask  = (minv ? MSB_MASK : '0) | (linv ? LOW_MASK : '0);
  assign blank_sel = blank_req & ~(out_disable | stby | test | linv | minv);

  always_comb begin
    if (stby)           word_d = '0;
    else if (test)      word_d = ALT ^ inv_mask;
    else if (blank_sel) word_d = BLANK;
    else                word_d = tap ^ inv_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout <= '0;
    else        dout <= word_d;
  end

  assign dout_en = ~out_disable;
endmodule

module adc_out_formatter_chk #(
  parameter int W          = 10,
  parameter int BLANK_CODE = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         out_disable,
  input logic         blank_req,
  input logic         stby,
  input logic         test,
  input logic         linv,
  input logic         minv,
  input logic [W-1:0] tap,
  input logic [W-1:0] dout
);
  localparam logic [W-1:0] PAT = {(W+1)/2{2'b01}};

  a_r3_standby_low: assert property (@(posedge clk) disable iff (!rst_n)
    stby |=> dout == '0);

  a_r4_test_word: assert property (@(posedge clk) disable iff (!rst_n)
    (test && !stby) |=> dout == (PAT ^ {$past(minv), {(W-1){$past(linv)}}}));

  a_r5_invert: assert property (@(posedge clk) disable iff (!rst_n)
    (!stby && !test && (linv || minv)) |=>
      dout == ($past(tap) ^ {$past(minv), {(W-1){$past(linv)}}}));

  a_r6_blank_code: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_req && !out_disable && !stby && !test && !linv && !minv) |=>
      dout == W'(BLANK_CODE));

  a_r1_normal_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank_req && !stby && !test && !linv && !minv) |=> dout == $past(tap));
endmodule

bind adc_out_formatter adc_out_formatter_chk #(.W(W), .BLANK_CODE(BLANK_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_disable(out_disable), .blank_req(blank_req),
  .stby(stby), .test(test), .linv(linv), .minv(minv), .tap(tap), .dout(dout)
);

// File: tb/adc_out_formatter_tb_top.sv
`timescale 1ns/1ps
module adc_out_formatter_tb_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [9:0] sample_in = '0;
  logic       out_disable = 0, blank_req = 0, stby = 0, test = 0, linv = 0, minv = 0;
  logic [9:0] dout;
  logic       dout_en;

  int checks = 0, errors = 0;
  bit active = 0;

  typedef struct {
    logic [9:0] d;
    logic       en;
    string      req;
  } exp_t;
  exp_t q[$];

  logic [9:0] hist [4];
  bit prev_blank = 0;

  adc_out_formatter dut_i (
    .clk(clk), .rst_n(rst_n), .sample_in(sample_in), .out_disable(out_disable),
    .blank_req(blank_req), .stby(stby), .test(test), .linv(linv), .minv(minv),
    .dout(dout), .dout_en(dout_en)
  );

  always #2 clk = ~clk;

  task automatic step(input logic [9:0] s, input logic oe, input logic pb,
                      input logic sb, input logic ts, input logic li, input logic mi);
    exp_t e;
    logic [9:0] mask;
    @(negedge clk);
    sample_in = s; out_disable = oe; blank_req = pb;
    stby = sb; test = ts; linv = li; minv = mi;
    mask = {mi, {9{li}}};
    e.en = !oe;
    if (sb) begin
      e.d = '0; e.req = "R3";
    end else if (ts) begin
      e.d = 10'h155 ^ mask; e.req = "R4";
    end else if (pb && !oe && !li && !mi) begin
      e.d = 10'd32; e.req = "R6";
    end else begin
      e.d = hist[3] ^ mask;
      e.req = pb ? "R7" : prev_blank ? "R8" : (li || mi) ? "R5" : "R1";
    end
    if (oe) e.req = {e.req, "/R2"};
    prev_blank = pb && !oe && !sb && !ts && !li && !mi;
    q.push_back(e);
    hist[3] = hist[2]; hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = s;
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (active && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (dout !== e.d || dout_en !== e.en) begin
          errors++;
          $display("FAIL %s: dout=%h en=%b expected dout=%h en=%b", e.req, dout, dout_en, e.d, e.en);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : driver
    for (int i = 0; i < 4; i++) hist[i] = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (dout !== 10'd0 || dout_en !== 1'b1) begin
      errors++;
      $display("FAIL R9: reset dout=%h en=%b expected dout=000 en=1", dout, dout_en);
    end
    rst_n = 1;
    active = 1;
    // R9/R1: zero words drain, then boundary codes pass unchanged
    step(10'd0, 0,0,0,0,0,0);
    step(10'd511, 0,0,0,0,0,0);
    step(10'd1023, 0,0,0,0,0,0);
    for (int i = 0; i < 12; i++) step(10'((i * 37 + 5) % 1024), 0,0,0,0,0,0);
    // R5: inversion variants
    for (int i = 0; i < 6; i++) step(10'(i * 171), 0,0,0,0,0,1);
    for (int i = 0; i < 6; i++) step(10'(i * 93 + 1), 0,0,0,0,1,0);
    for (int i = 0; i < 6; i++) step(10'(1023 - i * 77), 0,0,0,0,1,1);
    // R4: all four test words
    step(10'd7, 0,0,0,1,0,0);
    step(10'd8, 0,0,0,1,0,1);
    step(10'd9, 0,0,0,1,1,0);
    step(10'd10, 0,0,0,1,1,1);
    // R3: standby overrides test, inversion and blanking
    step(10'd11, 0,0,1,0,0,0);
    step(10'd12, 0,1,1,1,1,1);
    // R6 then R8: blanking and its release
    for (int i = 0; i < 4; i++) step(10'(300 + i), 0,1,0,0,0,0);
    step(10'd400, 0,0,0,0,0,0);
    step(10'd401, 0,0,0,0,0,0);
    // R7: blanking ignored under other controls
    step(10'd500, 0,1,0,0,1,0);
    step(10'd501, 0,1,0,0,0,1);
    step(10'd502, 0,1,0,1,0,0);
    step(10'd503, 1,1,0,0,0,0);
    // R2: output disabled with mixed controls
    step(10'd600, 1,0,0,0,0,0);
    step(10'd601, 1,0,1,0,0,0);
    step(10'd602, 1,0,0,1,1,0);
    for (int i = 0; i < 8; i++) step(10'(700 + i * 40), 0,0,0,0,0,0);
    @(negedge clk);
    @(negedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule